// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Error Flags

This block receives characters from an asynchronous serial line. A sample-tick input sets the baud rate and gives 16 ticks per bit. The block synchronises the line and checks that each start bit is genuine. It then shifts in eight data bits, least significant bit first. A parity bit follows if one is enabled, and the stop bit is sampled last. The finished character goes into a receive buffer.

Each character is checked for three faults: a wrong parity bit, a low stop bit, and an unread buffer being overwritten. Each fault has its own flag in a status word. The two registers are read through a small bus port: address 0 gives the buffer and address 1 gives the status word. Each character produces a one-cycle completion pulse. A faulty character also produces a one-cycle error pulse. A mask input can withhold the completion pulse for faulty characters, so software handles them only through the error pulse.

The block has no break detector. A line held low for about two character times shows up as two framing errors in a row, each with data 00h.

Top module: `uart_rx_err`

## Requirements
- R1: A valid frame stores its eight data bits, received LSB first, in the buffer (read at rd_addr=0). The character's `irq_done` and `irq_err` pulses each last exactly one clock cycle.
- R2: A low line is taken as a start bit only if it is still low at the mid-bit sample, eight ticks after detection. Otherwise the receiver returns to idle and reports nothing.
- R3: Parity mode encoding: 00 = no parity bit, 01 = even, 10 = odd, 11 = parity bit always 0. With mode 00 the frame has no parity slot and status bit 0 is never set.
- R4: If the received parity bit differs from the bit the parity mode expects, status bit 0 (parity) is set.
- R5: If the stop-bit sample is low, status bit 1 (framing) is set.
- R6: If a character completes while the buffer still holds an unread character, status bit 2 (overrun) is set and the buffer takes the new character.
- R7: A character with any of the three errors produces a one-cycle `irq_err` pulse, issued together with its status update.
- R8: A read of the buffer (rd_en=1, rd_addr=0) clears all status bits on the next clock edge.
- R9: Each completed character replaces the whole status word. Only its own errors appear, and flags from earlier characters are gone.
- R10: When `err_mask`=1, a character with an error produces no `irq_done` pulse. When `err_mask`=0, every character pulses `irq_done`.
- R11: A low line lasting 19.5 bit times, with parity mode 00, gives exactly two characters, each with data 00h and the framing flag set.
- R12: After reset the buffer and status read as 0 and both interrupt outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Sample tick, 16 per bit time |
| rxd | input | 1 | Serial line, idle high |
| par_mode | input | 2 | Parity mode (see R3) |
| err_mask | input | 1 | 1 = withhold completion pulse on errored characters |
| rd_en | input | 1 | Read strobe; clears status when address is 0 |
| rd_addr | input | 1 | 0 = receive buffer, 1 = status word |
| rd_data | output | 8 | Read data for the selected register |
| irq_done | output | 1 | One-cycle receive-complete pulse |
| irq_err | output | 1 | One-cycle receive-error pulse |

## Verification
A bit counter or tick phase that slips shows up as wrong data in the buffer at the very next completion pulse. A shift of one position gives a rotated character, and a wrong phase gives a false framing or parity flag. A stale buffer-full state shows up one character later, as a missing or spurious overrun bit. A status word that fails to clear is visible at the read that follows the buffer read. An error pulse with no flag behind it is caught on the cycle it occurs.

// File: rtl/uart_rx_pkg.sv
// Shared types for the serial receiver: parity mode encoding and status flags.
// Assumes: status flags are packed with parity in bit 0, framing in bit 1, overrun in bit 2.
package uart_rx_pkg;
    typedef enum logic [1:0] {
        PAR_NONE = 2'b00,
        PAR_EVEN = 2'b01,
        PAR_ODD  = 2'b10,
        PAR_ZERO = 2'b11
    } par_mode_e;

    typedef struct packed {
        logic ovr;
        logic frm;
        logic par;
    } rx_stat_t;
endpackage

// File: rtl/uart_rx_sync.sv
// Multi-stage synchroniser for the asynchronous serial line.
// Assumes: the line idles high, so every stage resets to 1.
module uart_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] sync_q;

    // Shift the raw line through the synchroniser stages.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[STAGES-2:0], din};
    end

    assign dout = sync_q[STAGES-1];
endmodule

// File: rtl/uart_rx_parity.sv
// Works out whether a parity bit is expected and what its value should be.
// Assumes: the data input is stable once all data bits are shifted in.
module uart_rx_parity
    import uart_rx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] data,
    input  logic [1:0]        mode,
    output logic              has_par,
    output logic              exp_bit
);
    // Expected parity bit for each mode.
    always_comb begin
        has_par = (par_mode_e'(mode) != PAR_NONE);
        case (par_mode_e'(mode))
            PAR_EVEN: exp_bit = ^data;
            PAR_ODD:  exp_bit = ~(^data);
            default:  exp_bit = 1'b0;
        endcase
    end
endmodule

// File: rtl/uart_rx_frame.sv
// Frame engine: validates the start bit, samples the data, parity and stop bits
// at mid-bit, and emits a one-cycle done strobe with the character and its error bits.
// Assumes: OVS sample ticks per bit; tick is a single-cycle strobe.
module uart_rx_frame
    import uart_rx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OVS    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              rx,
    input  logic [1:0]        par_mode,
    output logic              done,
    output logic [DATA_W-1:0] data,
    output logic              par_err,
    output logic              frm_err
);
    localparam int CNT_W = $clog2(OVS);
    localparam int BIT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [CNT_W-1:0] MID  = CNT_W'(OVS/2 - 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(OVS - 1);
    localparam logic [BIT_W-1:0] TOPB = BIT_W'(DATA_W - 1);

    typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP} st_e;

    st_e              state;
    logic [CNT_W-1:0] cnt;
    logic [BIT_W-1:0] bitn;
    logic             has_par;
    logic             exp_bit;

    uart_rx_parity #(.DATA_W(DATA_W)) i_par (
        .data    (data),
        .mode    (par_mode),
        .has_par (has_par),
        .exp_bit (exp_bit)
    );

    // Bit-timing state machine; acts only on sample ticks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= S_IDLE;
            cnt     <= '0;
            bitn    <= '0;
            data    <= '0;
            par_err <= 1'b0;
            frm_err <= 1'b0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            if (tick) begin
                case (state)
                    S_IDLE: begin
                        if (!rx) begin
                            cnt   <= '0;
                            state <= S_START;
                        end
                    end
                    S_START: begin
                        if (cnt == MID) begin
                            cnt     <= '0;
                            bitn    <= '0;
                            par_err <= 1'b0;
                            state   <= rx ? S_IDLE : S_DATA;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    S_DATA: begin
                        if (cnt == LAST) begin
                            cnt  <= '0;
                            data <= {rx, data[DATA_W-1:1]};
                            if (bitn == TOPB) state <= has_par ? S_PAR : S_STOP;
                            else              bitn  <= bitn + 1'b1;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    S_PAR: begin
                        if (cnt == LAST) begin
                            cnt     <= '0;
                            par_err <= (rx != exp_bit);
                            state   <= S_STOP;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    S_STOP: begin
                        if (cnt == LAST) begin
                            cnt     <= '0;
                            frm_err <= !rx;
                            done    <= 1'b1;
                            state   <= S_IDLE;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    default: state <= S_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/uart_rx_regs.sv
// Receive buffer, status word, interrupt pulses and read port.
// Assumes: done is a single-cycle strobe; a completed character wins over a
// buffer read in the same cycle.
module uart_rx_regs
    import uart_rx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              done,
    input  logic [DATA_W-1:0] data,
    input  logic              par_err,
    input  logic              frm_err,
    input  logic              err_mask,
    input  logic              rd_en,
    input  logic              rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq_done,
    output logic              irq_err,
    output rx_stat_t          stat
);
    localparam int PAD_W = DATA_W - $bits(rx_stat_t);

    logic [DATA_W-1:0] buf_q;
    logic              full_q;
    logic              rd_buf;
    rx_stat_t          nxt;
    logic              any_err;

    assign rd_buf  = rd_en && !rd_addr;
    assign nxt     = '{ovr: full_q && !rd_buf, frm: frm_err, par: par_err};
    assign any_err = |nxt;

    // Capture characters, update flags and raise interrupt pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_q    <= '0;
            full_q   <= 1'b0;
            stat     <= '0;
            irq_done <= 1'b0;
            irq_err  <= 1'b0;
        end else begin
            irq_done <= 1'b0;
            irq_err  <= 1'b0;
            if (done) begin
                buf_q    <= data;
                full_q   <= 1'b1;
                stat     <= nxt;
                irq_err  <= any_err;
                irq_done <= !(err_mask && any_err);
            end else if (rd_buf) begin
                full_q <= 1'b0;
                stat   <= '0;
            end
        end
    end

    // Read multiplexer.
    assign rd_data = rd_addr ? {{PAD_W{1'b0}}, stat} : buf_q;
endmodule

// File: rtl/uart_rx_err.sv
// Top of the serial receiver: synchroniser, frame engine and register bank.
// Assumes: tick gives 16 strobes per bit; rxd may be asynchronous to clk.
module uart_rx_err
    import uart_rx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OVS    = 16,
    parameter int SYNC_N = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              rxd,
    input  logic [1:0]        par_mode,
    input  logic              err_mask,
    input  logic              rd_en,
    input  logic              rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq_done,
    output logic              irq_err
);
    logic              rx_s;
    logic              frm_done;
    logic [DATA_W-1:0] frm_data;
    logic              frm_par;
    logic              frm_stop;
    rx_stat_t          stat_q;

    uart_rx_sync #(.STAGES(SYNC_N)) i_sync (
        .clk (clk), .rst_n (rst_n), .din (rxd), .dout (rx_s)
    );

    uart_rx_frame #(.DATA_W(DATA_W), .OVS(OVS)) i_frame (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .rx       (rx_s),
        .par_mode (par_mode),
        .done     (frm_done),
        .data     (frm_data),
        .par_err  (frm_par),
        .frm_err  (frm_stop)
    );

    uart_rx_regs #(.DATA_W(DATA_W)) i_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .done     (frm_done),
        .data     (frm_data),
        .par_err  (frm_par),
        .frm_err  (frm_stop),
        .err_mask (err_mask),
        .rd_en    (rd_en),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .irq_done (irq_done),
        .irq_err  (irq_err),
        .stat     (stat_q)
    );
endmodule

// File: rtl/uart_rx_err_chk.sv
// Property checker for the serial receiver, attached to the top by bind.
// Assumes: stat is {overrun, framing, parity}.
module uart_rx_err_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       irq_done,
    input logic       irq_err,
    input logic       err_mask,
    input logic [1:0] par_mode,
    input logic       rd_en,
    input logic       rd_addr,
    input logic       frm_done,
    input logic [2:0] stat
);
    assert_done_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
        irq_done |=> !irq_done);

    assert_err_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_err |=> !irq_err);

    assert_err_has_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_err |-> (stat != 3'b000));

    assert_no_par_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq_done || irq_err) && par_mode == 2'b00) |-> !stat[0]);

    assert_read_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !rd_addr && !frm_done) |=> (stat == 3'b000));

    assert_mask_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (err_mask && irq_err) |-> !irq_done);
endmodule

bind uart_rx_err uart_rx_err_chk i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .irq_done (irq_done),
    .irq_err  (irq_err),
    .err_mask (err_mask),
    .par_mode (par_mode),
    .rd_en    (rd_en),
    .rd_addr  (rd_addr),
    .frm_done (frm_done),
    .stat     (stat_q)
);

// File: tb/test_uart_rx_err.sv
// Scoreboard bench: the driver queues expected characters, the monitor pops
// and compares them at every interrupt pulse.
module test_uart_rx_err;
    localparam int BITCLK = 64;  // 16 ticks x 4 clocks

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick;
    logic       rxd = 1'b1;
    logic [1:0] par_mode = 2'b00;
    logic       err_mask = 1'b0;
    logic       rd_en = 1'b0;
    logic       rd_addr = 1'b0;
    logic [7:0] rd_data;
    logic       irq_done;
    logic       irq_err;
    logic [1:0] tdiv = 2'd0;

    typedef struct {
        logic [7:0] data;
        logic       done;
        logic       err;
        logic [2:0] st;
        logic       consume;
        string      req;
    } exp_t;

    exp_t q[$];
    int   checks = 0;
    int   errors = 0;
    int   events = 0;
    logic prev_unread = 1'b0;

    always #5 clk = ~clk;
    always @(posedge clk) tdiv <= tdiv + 2'd1;
    assign tick = (tdiv == 2'd3);

    uart_rx_err i_uart_rx_err (
        .clk (clk), .rst_n (rst_n), .tick (tick), .rxd (rxd),
        .par_mode (par_mode), .err_mask (err_mask),
        .rd_en (rd_en), .rd_addr (rd_addr), .rd_data (rd_data),
        .irq_done (irq_done), .irq_err (irq_err)
    );

    task automatic check(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic hold(input logic b, input int clocks);
        @(negedge clk);
        rxd = b;
        repeat (clocks - 1) @(negedge clk);
    endtask

    // Driver: queue the expected result, then send one frame.
    task automatic send(input logic [7:0] d, input logic bad_par, input logic stop,
                        input logic consume, input string req);
        exp_t e;
        logic pbit;
        logic pe;
        case (par_mode)
            2'b01:   pbit = ^d;
            2'b10:   pbit = ~(^d);
            default: pbit = 1'b0;
        endcase
        pbit = pbit ^ bad_par;
        pe = bad_par && (par_mode != 2'b00);
        e.data = d;
        e.st = {prev_unread, !stop, pe};
        e.err = (e.st != 3'b000);
        e.done = !(err_mask && e.err);
        e.consume = consume;
        e.req = req;
        q.push_back(e);
        prev_unread = !consume;
        hold(1'b0, BITCLK);
        for (int i = 0; i < 8; i++) hold(d[i], BITCLK);
        if (par_mode != 2'b00) hold(pbit, BITCLK);
        hold(stop, BITCLK);
        hold(1'b1, 2 * BITCLK);
    endtask

    // Monitor: compare each interrupt event with the head of the queue.
    initial begin
        forever begin
            @(negedge clk);
            if (irq_done || irq_err) begin
                exp_t e;
                events++;
                if (q.size() == 0) begin
                    check(1'b0, "R2 unexpected event", events, 0);
                end else begin
                    e = q.pop_front();
                    check(irq_done == e.done, {e.req, " irq_done (R1/R10)"}, irq_done, e.done);
                    check(irq_err == e.err, {e.req, " irq_err (R7)"}, irq_err, e.err);
                    rd_addr = 1'b1;
                    #1;
                    check(rd_data == {5'b0, e.st}, {e.req, " status (R4/R5/R6/R9)"}, rd_data, e.st);
                    rd_addr = 1'b0;
                    #1;
                    check(rd_data == e.data, {e.req, " buffer (R1)"}, rd_data, e.data);
                    if (e.consume) begin
                        rd_en = 1'b1;
                        @(negedge clk);
                        rd_en = 1'b0;
                        rd_addr = 1'b1;
                        #1;
                        check(rd_data == 8'h00, {e.req, " status cleared by read (R8)"}, rd_data, 0);
                        rd_addr = 1'b0;
                    end
                end
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Main sequence.
    initial begin
        int ev0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        rd_addr = 1'b0;
        #1;
        check(rd_data == 8'h00, "R12 buffer after reset", rd_data, 0);
        rd_addr = 1'b1;
        #1;
        check(rd_data == 8'h00, "R12 status after reset", rd_data, 0);
        rd_addr = 1'b0;
        check(!irq_done && !irq_err, "R12 interrupts after reset", {irq_done, irq_err}, 0);
        hold(1'b1, BITCLK);

        par_mode = 2'b00; send(8'hA5, 1'b0, 1'b1, 1'b1, "R1 plain");
        par_mode = 2'b01; send(8'h3C, 1'b0, 1'b1, 1'b1, "R3 even");
        par_mode = 2'b10; send(8'h81, 1'b0, 1'b1, 1'b1, "R3 odd");
        par_mode = 2'b11; send(8'h7E, 1'b0, 1'b1, 1'b1, "R3 zero");
        par_mode = 2'b01; send(8'h96, 1'b1, 1'b1, 1'b1, "R4 bad parity");
        par_mode = 2'b00; send(8'h55, 1'b0, 1'b0, 1'b1, "R5 low stop");
        err_mask = 1'b1;
        par_mode = 2'b10; send(8'hC3, 1'b1, 1'b1, 1'b0, "R10 masked parity");
        send(8'h12, 1'b0, 1'b1, 1'b1, "R6 R9 overrun replaces flags");
        err_mask = 1'b0;
        par_mode = 2'b00;

        // R2: short low glitch must not start a frame.
        ev0 = events;
        hold(1'b0, 16);
        hold(1'b1, 3 * BITCLK);
        check(events == ev0, "R2 false start ignored", events - ev0, 0);

        // R11: long low line gives two framing errors with data 00h.
        begin
            exp_t e;
            e.data = 8'h00; e.st = {prev_unread, 1'b1, 1'b0}; e.err = 1'b1; e.done = 1'b1;
            e.consume = 1'b1; e.req = "R11 break first";
            q.push_back(e);
            e.st = 3'b010; e.req = "R11 break second";
            q.push_back(e);
            prev_unread = 1'b0;
        end
        ev0 = events;
        hold(1'b0, 19 * BITCLK + BITCLK / 2);
        hold(1'b1, 4 * BITCLK);
        check(events - ev0 == 2, "R11 break event count", events - ev0, 2);

        check(q.size() == 0, "R1 all expected characters seen", q.size(), 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule